// File: doc/BRIEF.md
# Power-management device command access engine

This block lets a host run single read or write transactions on a power-management device reached over a four-wire serial link. The host writes one 32-bit command word. That word holds the transfer direction, a halfword address and the write data. The engine frames the command onto the link with an active-low chip-select and a divided serial clock. For a read, it then clocks in sixteen bits of reply. It reports its progress, the reply data and a device-ready flag in one status word.

A write finishes on its own: the engine is idle again as soon as the last command bit is sent. A read ends in a holding state. There the reply stays visible in the status word until the host writes a valid-clear strobe. The host polls for idle before it issues a command, and for the holding state before it takes the data. A command that arrives while the engine is busy is dropped and marks a sticky error flag.

Top module: `pmic_cmd_engine`

## Requirements
- R1: After reset the status word reads zero apart from bit 21, chip-select is high and the serial clock is low.
- R2: A command strobe taken while the state field (status bits 18:16) reads idle (0) moves the state to send (2) one cycle later. In the command word, bit 31 = 1 means write and 0 means read, bits 30:16 are the halfword address and bits 15:0 are the write data.
- R3: A write sends 32 bits MSB first, equal to the command word. The state returns to idle (0) on the same clock edge that raises chip-select.
- R4: A read sends bits 31:16 of the command followed by sixteen zero bits. It keeps chip-select low for sixteen more bit periods and shifts in the reply MSB first. The state field reads receive (4) after the 32nd bit and hold (6) at the end of the frame, with the reply in status bits 15:0.
- R5: The hold state (6) lasts until a valid-clear strobe, which returns the state to idle. The reply data stays in bits 15:0 after the clear.
- R6: A command strobe taken in any state other than idle starts no frame and changes neither the state nor the link. It sets status bit 24, which stays set until reset.
- R7: A valid-clear strobe in any state other than hold changes nothing in the status word or on the link.
- R8: Each bit period lasts 2*CLK_DIV clocks: the serial clock is low for the first half and high for the second. MOSI holds the bit for the whole period. MISO is sampled on the rising serial clock edge. The serial clock stays low while chip-select is high.
- R9: Between two frames, chip-select stays high for at least CS_GAP*2*CLK_DIV clocks. A command issued sooner waits for the gap to end before its frame starts.
- R10: Status bit 21 follows the device-ready input. All unused status bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWr | input | 1 | One-cycle command write strobe |
| cmdData | input | 32 | Command word: direction, halfword address, write data |
| vldClrWr | input | 1 | One-cycle valid-clear strobe |
| initDoneIn | input | 1 | Device-ready flag shown in the status word |
| status | output | 32 | Reply data, state, ready flag, sticky error |
| spiCsN | output | 1 | Active-low chip-select |
| spiSck | output | 1 | Divided serial clock |
| spiMosi | output | 1 | Serial data to the device |
| spiMiso | input | 1 | Serial data from the device |

## Verification
The assertions assume that cmdWr and vldClrWr are single-cycle strobes synchronous to clk. They also assume that MISO changes only after a falling serial clock edge, so it is settled when the engine samples it on the rising edge. The stimulus drives every host input on the falling clk edge. The bench's device responder updates MISO only from the falling serial clock, and only during the sixteen reply periods of a read. A stray command and a stray clear are placed deliberately inside a read frame, to exercise the ignore rules while the link is busy.

// File: rtl/pmic_cmd_pkg.sv
package pmic_cmd_pkg;
  localparam int CMD_W    = 32;
  localparam int RD_W     = 16;
  localparam int FRAME_RD = CMD_W + RD_W;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEND = 3'd2,
    ST_RECV = 3'd4,
    ST_HOLD = 3'd6
  } engState_e;

  typedef struct packed {
    logic load;
    logic capture;
  } ctlStrobes_t;
endpackage

// File: rtl/pmic_access_ctl.sv
module pmic_access_ctl
  import pmic_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWr,
  input  logic        cmdWriteFlag,
  input  logic        vldClrWr,
  input  logic        txEnd,
  input  logic        frameEnd,
  output engState_e   state,
  output ctlStrobes_t strb,
  output logic        errFlag
);
  logic wrFlag;
  engState_e stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (cmdWr) stateNext = ST_SEND;
      ST_SEND: if (txEnd) stateNext = wrFlag ? ST_IDLE : ST_RECV;
      ST_RECV: if (frameEnd) stateNext = ST_HOLD;
      ST_HOLD: if (vldClrWr) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign strb.load    = cmdWr && (state == ST_IDLE);
  assign strb.capture = frameEnd && (state == ST_RECV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wrFlag  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.load) wrFlag <= cmdWriteFlag;
      if (cmdWr && (state != ST_IDLE)) errFlag <= 1'b1;
    end
  end

  AST_WRITE_BACK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND && txEnd && wrFlag) |=> (state == ST_IDLE)); // R3
  AST_RECV_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECV) |-> !wrFlag); // R4
  AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !vldClrWr) |=> (state == ST_HOLD)); // R5
  AST_BUSY_CMD_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && state != ST_IDLE) |=> errFlag); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R6
  AST_STRAY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (vldClrWr && state == ST_RECV && !frameEnd) |=> (state == ST_RECV)); // R7
endmodule

// File: rtl/pmic_spi_shifter.sv
module pmic_spi_shifter
  import pmic_cmd_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              spiMiso,
  output logic              spiCsN,
  output logic              spiSck,
  output logic              spiMosi,
  output logic              txEnd,
  output logic              frameEnd,
  output logic [RD_W-1:0]   rdData
);
  localparam int PERIOD  = 2 * CLK_DIV;
  localparam int PHASE_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int BIT_W   = $clog2(FRAME_RD + 1);
  localparam int GAP_CYC = CS_GAP * PERIOD;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  logic               pending, active, isRd;
  logic [PHASE_W-1:0] phaseCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [CMD_W-1:0]   shiftReg;
  logic [RD_W-1:0]    rxReg;
  logic [GAP_W-1:0]   gapCnt;
  logic [BIT_W-1:0]   lastBit;
  logic               bitEnd, sampleNow;

  assign lastBit   = isRd ? BIT_W'(FRAME_RD - 1) : BIT_W'(CMD_W - 1);
  assign bitEnd    = active && (phaseCnt == PHASE_W'(PERIOD - 1));
  assign txEnd     = bitEnd && (bitCnt == BIT_W'(CMD_W - 1));
  assign frameEnd  = bitEnd && (bitCnt == lastBit);
  assign sampleNow = active && (phaseCnt == PHASE_W'(CLK_DIV - 1))
                     && (bitCnt >= BIT_W'(CMD_W));

  assign spiCsN  = !active;
  assign spiSck  = active && (phaseCnt >= PHASE_W'(CLK_DIV));
  assign spiMosi = active && shiftReg[CMD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      active   <= 1'b0;
      isRd     <= 1'b0;
      phaseCnt <= '0;
      bitCnt   <= '0;
      shiftReg <= '0;
      rxReg    <= '0;
      rdData   <= '0;
      gapCnt   <= '0;
    end else begin
      if (strb.load) begin
        shiftReg <= cmdWord[CMD_W-1] ? cmdWord
                                     : {cmdWord[CMD_W-1:RD_W], {RD_W{1'b0}}};
        isRd     <= !cmdWord[CMD_W-1];
        pending  <= 1'b1;
      end else if (bitEnd) begin
        shiftReg <= {shiftReg[CMD_W-2:0], 1'b0};
      end

      if (active) begin
        phaseCnt <= bitEnd ? '0 : phaseCnt + 1'b1;
        if (frameEnd) begin
          active <= 1'b0;
          gapCnt <= GAP_W'(GAP_CYC);
        end else if (bitEnd) begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else if (gapCnt != '0) begin
        gapCnt <= gapCnt - 1'b1;
      end else if (pending) begin
        active   <= 1'b1;
        pending  <= 1'b0;
        phaseCnt <= '0;
        bitCnt   <= '0;
      end

      if (sampleNow) rxReg <= {rxReg[RD_W-2:0], spiMiso};
      if (strb.capture) rdData <= rxReg;
    end
  end

  AST_CS_RISES_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> spiCsN); // R8
  AST_GAP_HOLDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    (!active && gapCnt != '0) |=> spiCsN); // R9
  AST_LAUNCH_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> $past(pending)); // R9
endmodule

// File: rtl/pmic_cmd_engine.sv
module pmic_cmd_engine
  import pmic_cmd_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWr,
  input  logic [31:0] cmdData,
  input  logic        vldClrWr,
  input  logic        initDoneIn,
  output logic [31:0] status,
  output logic        spiCsN,
  output logic        spiSck,
  output logic        spiMosi,
  input  logic        spiMiso
);
  engState_e       state;
  ctlStrobes_t     strb;
  logic            errFlag, txEnd, frameEnd;
  logic [RD_W-1:0] rdData;

  pmic_access_ctl uCtl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdWriteFlag(cmdData[31]),
    .vldClrWr(vldClrWr), .txEnd(txEnd), .frameEnd(frameEnd),
    .state(state), .strb(strb), .errFlag(errFlag)
  );

  pmic_spi_shifter #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) uShift (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdWord(cmdData),
    .spiMiso(spiMiso), .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi),
    .txEnd(txEnd), .frameEnd(frameEnd), .rdData(rdData)
  );

  assign status = {7'b0, errFlag, 2'b0, initDoneIn, 2'b0, state, rdData};
endmodule

// File: tb/pmic_cmd_engine_test.sv
`timescale 1ns/1ps
module pmic_cmd_engine_test;
  localparam int DIV = 2;
  localparam int GAPP = 2;
  localparam int BP = 2 * DIV;
  localparam int GAPC = GAPP * BP;

  logic clk = 0, rstN = 0, cmdWr = 0, vldClrWr = 0, initDoneIn = 0;
  logic [31:0] cmdData = 0;
  logic [15:0] respData = 0;
  logic [31:0] status;
  logic spiCsN, spiSck, spiMosi;
  logic misoR = 0;

  int nCmp = 0, nBad = 0;
  bit finished = 0;

  pmic_cmd_engine #(.CLK_DIV(DIV), .CS_GAP(GAPP)) uut (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData),
    .vldClrWr(vldClrWr), .initDoneIn(initDoneIn), .status(status),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(misoR)
  );

  always #2 clk = ~clk;

  // device responder: reply bits change only after a falling serial clock
  int rEdges = 0;
  always @(negedge spiCsN) rEdges = 0;
  always @(posedge spiSck) rEdges = rEdges + 1;
  always @(negedge spiSck)
    if (rEdges >= 32 && rEdges < 48) misoR = respData[47 - rEdges];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  // behavioural reference
  int mState = 0, mCyc = -1, mGap = 0, mBits = 32;
  bit mErr = 0, mPend = 0, mWr = 0;
  logic [15:0] mRd = 0;
  logic [31:0] mFrame = 0;
  int highRun = 0;
  bit seenFrame = 0;

  always @(posedge clk) begin
    bit txLast, frLast, doLoad;
    int nxt, bitIdx;
    string stTag;
    if (!rstN) begin
      mState = 0; mCyc = -1; mGap = 0; mBits = 32;
      mErr = 0; mPend = 0; mWr = 0; mRd = 0; mFrame = 0;
    end else begin
      txLast = (mCyc == BP * 32 - 1);
      frLast = (mCyc >= 0) && (mCyc == BP * mBits - 1);
      doLoad = 0;
      nxt = mState;
      case (mState)
        0: if (cmdWr) begin nxt = 2; doLoad = 1; end
        2: if (txLast) nxt = mWr ? 0 : 4;
        4: if (frLast) begin nxt = 6; mRd = respData; end
        6: if (vldClrWr) nxt = 0;
        default: nxt = 0;
      endcase
      if (cmdWr && mState != 0) mErr = 1;
      if (mCyc >= 0) begin
        if (frLast) begin mCyc = -1; mGap = GAPC; end
        else mCyc = mCyc + 1;
      end else if (mGap > 0) mGap = mGap - 1;
      else if (mPend) begin mCyc = 0; mPend = 0; end
      if (doLoad) begin
        mPend = 1;
        mWr = cmdData[31];
        mBits = cmdData[31] ? 32 : 48;
        mFrame = cmdData[31] ? cmdData : {cmdData[31:16], 16'h0};
      end
      mState = nxt;
    end
    #1;
    if (rstN) begin
      case (mState)
        0: stTag = "R3"; 2: stTag = "R2"; 4: stTag = "R4"; default: stTag = "R5";
      endcase
      bitIdx = (mCyc >= 0) ? mCyc / BP : 0;
      chk(stTag, {29'b0, status[18:16]}, mState);
      chk("R4", {16'b0, status[15:0]}, {16'b0, mRd});
      chk("R6", {31'b0, status[24]}, {31'b0, mErr});
      chk("R10", {status[31:25], status[23:22], status[21], status[20:19]},
          {7'b0, 2'b0, initDoneIn, 2'b0});
      chk("R9", {31'b0, spiCsN}, {31'b0, (mCyc < 0)});
      chk("R8", {31'b0, spiSck}, {31'b0, (mCyc >= 0) && ((mCyc % BP) >= DIV)});
      chk("R3", {31'b0, spiMosi},
          {31'b0, (mCyc >= 0) && (bitIdx < 32) && mFrame[31 - bitIdx]});
      if (spiCsN) highRun++;
      else begin
        if (highRun > 0 && seenFrame) chk("R9", {31'b0, highRun >= GAPC}, 32'd1);
        if (highRun > 0) seenFrame = 1;
        highRun = 0;
      end
    end
  end

  task automatic issueCmd(logic [31:0] c);
    @(negedge clk); cmdWr = 1; cmdData = c;
    @(negedge clk); cmdWr = 0;
  endtask

  task automatic clearValid();
    @(negedge clk); vldClrWr = 1;
    @(negedge clk); vldClrWr = 0;
  endtask

  task automatic waitState(logic [2:0] s);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (status[18:16] == s) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] snap;
    repeat (4) @(negedge clk);
    chk("R1", status, 32'h0);
    chk("R1", {30'b0, spiCsN, spiSck}, 32'd2);
    rstN = 1; initDoneIn = 1;
    @(negedge clk);
    chk("R1", status, 32'h0020_0000);

    // two writes back to back: second waits out the chip-select gap
    issueCmd({1'b1, 15'h00D2, 16'hBEEF});
    chk("R2", {29'b0, status[18:16]}, 32'd2);
    waitState(3'd0);
    issueCmd({1'b1, 15'h1234, 16'h0F0F});
    waitState(3'd0);
    repeat (5) @(negedge clk);

    // read with stray command and stray clear inside the frame
    respData = 16'hA5C3;
    issueCmd({1'b0, 15'h0042, 16'hFFFF});
    repeat (10) @(negedge clk);
    issueCmd({1'b1, 15'h7777, 16'h1111});
    chk("R6", {31'b0, status[24]}, 32'd1);
    clearValid();
    chk("R7", {29'b0, status[18:16]}, 32'd2);
    waitState(3'd6);
    repeat (20) @(negedge clk);
    chk("R5", {29'b0, status[18:16]}, 32'd6);
    chk("R4", {16'b0, status[15:0]}, 32'h0000_A5C3);
    clearValid();
    chk("R5", {13'b0, status[18:0]}, 32'h0000_A5C3);

    // stray clear while idle
    repeat (3) @(negedge clk);
    snap = status;
    clearValid();
    repeat (2) @(negedge clk);
    chk("R7", status, snap);

    // reply pattern extremes, then a write right after a read
    respData = 16'h0001;
    issueCmd({1'b0, 15'h7FFF, 16'h0000});
    waitState(3'd6);
    chk("R4", {16'b0, status[15:0]}, 32'h0000_0001);
    clearValid();
    respData = 16'hFFFF;
    issueCmd({1'b0, 15'h0001, 16'h5A5A});
    waitState(3'd6);
    chk("R4", {16'b0, status[15:0]}, 32'h0000_FFFF);
    clearValid();
    issueCmd({1'b1, 15'h4000, 16'h8001});
    waitState(3'd0);
    initDoneIn = 0;
    repeat (20) @(negedge clk);
    chk("R10", {31'b0, status[21]}, 32'd0);
    chk("R6", {31'b0, status[24]}, 32'd1);
    finishRun();
  end
endmodule